// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind an 8-bit bus. Software writes a control byte to a shared control address. The byte names a counter and sets that counter's byte access order and counting mode. A reload value then follows at the counter's own data address. Each counter divides its own count pulse stream by the reload value and drives one output. That output can be a periodic one-pulse-low rate signal, a square wave for a serial baud clock, or a single terminal-count flag. A per-counter gate input can pause a counter, and in the periodic modes it can also restart the count.

The block runs on one system clock. Each counter's clock input, `tick[i]`, is a synchronous count enable: every system clock edge that finds `tick[i]` and `gate[i]` high is one input clock for counter i. The bus uses addresses 0 to 2 for the three counters and address 3 for control. A control byte is laid out as select[7:6], access[5:4], mode[3:1] and decimal[0]. Reads return data one clock after the read strobe.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every `tout` bit is high, `rdata` is 0, and an unlatched read of any counter returns 0.
- R2: Control bits 7-6 pick the counter (0, 1 or 2). A control byte with select 3 changes no counter, whatever its other bits hold.
- R3: Access field bits 5-4 set how data moves. Code 1 loads the low byte and clears the high byte. Code 2 loads the high byte and clears the low byte. Code 3 takes the low byte on the first write and the high byte on the second. Reads follow the same order.
- R4: Mode field bits 3-1 work as follows: code 2 or 6 selects the rate mode, code 3 or 7 the square-wave mode, and code 0 the terminal-count mode. A programming byte with mode code 1, 4 or 5, or with bit 0 set, is rejected and leaves the counter unchanged.
- R5: In rate mode with reload N (N at least 2), the first input clock after loading loads the count. Counting from that input clock as number 0, the output is low only on input clocks where the remaining count is 1, so the period is N and the low time is exactly one input clock.
- R6: In square-wave mode with reload N, the output is high for ceil(N/2) input clocks and low for floor(N/2), with period N. An odd N gives the extra input clock to the high phase.
- R7: A reload of 0 counts as 65536. After loading, the count reads 0000h, and one input clock later it reads FFFFh.
- R8: While `gate[i]` is low, counter i does not count, and in the periodic modes its output is high by the next clock. A rising gate in a periodic mode makes the next input clock reload the count and restart the pattern.
- R9: An access code of 0 latches the current count of the selected counter. Reads then return the snapshot in the programmed order. A further latch is ignored until the snapshot has been fully read, and after that reads return the live count. A read of the control address returns 0.
- R10: In terminal-count mode, programming or completing a reload drives the output low. The output goes high on input clock N after the load input clock, and the counter then halts at 0 with the output high until it is written again.
- R11: In a periodic mode, a new reload written while the counter runs takes effect only when the current period ends.
- R12: The three counters count, latch and drive their outputs independently of each other.
- R13: `tout` changes only on a clock where a bus write, an enabled input clock or a low gate occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one clock per byte |
| rd_en | input | 1 | Bus read strobe, one clock per byte |
| addr | input | 2 | 0 to 2 select a counter, 3 selects control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the clock after `rd_en` |
| tick | input | 3 | Per-counter input clock enables |
| gate | input | 3 | Per-counter gate inputs |
| tout | output | 3 | Per-counter outputs |

## Verification
The properties assume that a rate-mode reload is at least 2. With a reload of 1 the output would stay low, and the one-clock-low check would not apply. The stillness and reserved-select properties only claim anything on clocks with no input clock and all gates high. The stimulus keeps bus cycles and input clocks on separate clocks in the directed tests. It draws random reloads from 2 to 60 and random modes from the four periodic codes, and it holds all gates high during the random phase. Extra input clocks on the counters that are not being checked test that the counters stay independent.

// File: rtl/tri_interval_timer.sv
module tri_interval_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [2:0] tick,
  input  logic [2:0] gate,
  output logic [2:0] tout
);
  localparam int NCH = 3;
  localparam int BW  = 8;
  localparam int CW  = 2 * BW;
  localparam logic [1:0] CTRL = 2'd3;
  localparam logic [CW:0] ONE = 1;

  wire [NCH*BW-1:0] rbyte_all;
  wire mode_ok = (wdata[3:1] == 3'd0) || wdata[2];
  wire ctl_ok  = (wdata[5:4] == 2'd0) || (mode_ok && !wdata[0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0]    acc, md;
    logic [CW-1:0] rl, lat, nrl;
    logic [CW:0]   cnt, cur;
    logic          wph, rph, pend, rstrt, run, oq, lat_v, gq, done;

    wire ctl_hit = wr_en && addr == CTRL && wdata[7:6] == 2'(i) && ctl_ok;
    wire dat_hit = wr_en && addr == 2'(i);
    wire rd_hit  = rd_en && addr == 2'(i);
    wire step    = tick[i] && gate[i];
    wire [CW:0] full = {rl == '0, rl};
    wire wrap = cnt == ONE;
    wire [CW:0] nxt = wrap ? full : cnt - ONE;
    wire [CW:0] hf  = wrap ? (full >> 1) : (cur >> 1);
    wire [1:0] nmd  = wdata[2] ? {1'b1, wdata[1]} : 2'b00;

    always_comb begin
      nrl  = rl;
      done = 1'b0;
      case (acc)
        2'd1: begin nrl = {8'h00, wdata}; done = 1'b1; end
        2'd2: begin nrl = {wdata, 8'h00}; done = 1'b1; end
        default:
          if (wph) begin nrl = {wdata, rl[BW-1:0]}; done = 1'b1; end
          else nrl = {rl[CW-1:BW], wdata};
      endcase
    end

    wire [CW-1:0] src = lat_v ? lat : cnt[CW-1:0];
    wire hi_sel = (acc == 2'd2) || (acc == 2'd3 && rph);
    assign rbyte_all[i*BW +: BW] = hi_sel ? src[CW-1:BW] : src[BW-1:0];
    assign tout[i] = oq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc <= 2'd3; md <= 2'b00; rl <= '0; lat <= '0;
        cnt <= '0; cur <= '0;
        wph <= 1'b0; rph <= 1'b0; pend <= 1'b0; rstrt <= 1'b0;
        run <= 1'b0; oq <= 1'b1; lat_v <= 1'b0; gq <= 1'b1;
      end else begin
        gq <= gate[i];
        if (step) begin
          if (pend || rstrt) begin
            cnt <= full; cur <= full;
            pend <= 1'b0; rstrt <= 1'b0; run <= 1'b1;
            oq <= md[1];
          end else if (run) begin
            if (!md[1]) begin
              cnt <= cnt - ONE;
              if (cnt == ONE) begin oq <= 1'b1; run <= 1'b0; end
            end else begin
              cnt <= nxt;
              if (wrap) cur <= full;
              oq <= md[0] ? (nxt > hf) : (nxt != ONE);
            end
          end
        end
        if (md[1] && !gate[i]) oq <= 1'b1;
        if (md[1] && run && gate[i] && !gq) rstrt <= 1'b1;

        if (ctl_hit) begin
          if (wdata[5:4] == 2'd0) begin
            if (!lat_v) begin lat <= cnt[CW-1:0]; lat_v <= 1'b1; rph <= 1'b0; end
          end else begin
            acc <= wdata[5:4]; md <= nmd;
            wph <= 1'b0; rph <= 1'b0; lat_v <= 1'b0;
            run <= 1'b0; pend <= 1'b0; rstrt <= 1'b0;
            oq <= nmd[1];
          end
        end
        if (dat_hit) begin
          rl <= nrl;
          if (acc == 2'd3) wph <= ~wph;
          if (done && (!md[1] || !run)) pend <= 1'b1;
          if (done && !md[1]) begin oq <= 1'b0; run <= 1'b0; end
        end
        if (rd_hit) begin
          if (acc == 2'd3) rph <= ~rph;
          if (acc != 2'd3 || rph) lat_v <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        2'd0:    rdata <= rbyte_all[BW-1:0];
        2'd1:    rdata <= rbyte_all[2*BW-1:BW];
        2'd2:    rdata <= rbyte_all[3*BW-1:2*BW];
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [2:0] tick,
  input logic [2:0] gate,
  input logic [2:0] tout,
  input logic [1:0] ch1_md
);
  p_reserved_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[7:6] == 2'd3 && tick == 3'b000 && gate == 3'b111)
    |=> $stable(tout));

  p_rate_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_md == 2'b10 && !tout[1] && tick[1] && gate[1] && !wr_en) |=> tout[1]);

  p_gate_low_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate[1] && ch1_md[1] && !(wr_en && addr == 2'd3)) |=> tout[1]);

  p_ctrl_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> rdata == 8'h00);

  p_tc_prog_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[7:6] == 2'd0 && wdata[5:4] != 2'd0 && wdata[3:0] == 4'd0)
    |=> !tout[0]);

  p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick == 3'b000 && gate == 3'b111) |=> $stable(tout));
endmodule

bind tri_interval_timer tri_interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .tout(tout),
  .ch1_md(g_ch[1].md)
);

// File: tb/tri_interval_timer_test.sv
`timescale 1ns/1ps
module tri_interval_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] tick = 3'b000;
  logic [2:0] gate = 3'b111;
  logic [2:0] tout;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  tri_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .tout(tout)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk); tick = m;
    @(negedge clk); tick = 3'b000;
  endtask

  task automatic setup(input int ch, input logic [2:0] md, input int n);
    bus_wr(2'd3, {2'(ch), 2'b11, md, 1'b0});
    bus_wr(2'(ch), n[7:0]);
    bus_wr(2'(ch), n[15:8]);
  endtask

  task automatic latch_read(input int ch, output int val);
    logic [7:0] lo, hi;
    bus_wr(2'd3, {2'(ch), 2'b00, 4'b0000});
    bus_rd(2'(ch), lo);
    bus_rd(2'(ch), hi);
    val = {hi, lo};
  endtask

  function automatic int per_out(input bit sq, input int n, input int j);
    int c = n - (j % n);
    return sq ? int'(c > n / 2) : int'(c != 1);
  endfunction

  task automatic run_per(input int ch, input bit sq, input int n,
                         input int j0, input int j1, input string req);
    for (int j = j0; j <= j1; j++) begin
      pulse(3'(1 << ch));
      check(req, tout[ch], per_out(sq, n, j));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 reset tout", tout, 7);
    check("R1 reset rdata", rdata, 0);
    bus_rd(2'd0, d);
    check("R1 reset count read", d, 0);

    setup(0, 3'b010, 5);
    run_per(0, 1'b0, 5, 0, 11, "R5 rate N=5");

    setup(1, 3'b011, 7);
    run_per(1, 1'b1, 7, 0, 15, "R6 square odd N=7");
    setup(1, 3'b011, 6);
    run_per(1, 1'b1, 6, 0, 13, "R6 square even N=6");

    setup(2, 3'b110, 4);
    run_per(2, 1'b0, 4, 0, 9, "R4 alias 6 as rate");
    setup(2, 3'b111, 5);
    run_per(2, 1'b1, 5, 0, 5, "R4 alias 7 as square");
    bus_wr(2'd3, {2'd2, 2'b11, 3'b001, 1'b0});
    bus_wr(2'd3, {2'd2, 2'b11, 3'b011, 1'b1});
    run_per(2, 1'b1, 5, 6, 14, "R4 rejected byte no effect");

    setup(0, 3'b010, 3);
    setup(1, 3'b011, 4);
    setup(2, 3'b011, 5);
    for (int j = 0; j <= 20; j++) begin
      pulse(3'b111);
      check("R12 ch0", tout[0], per_out(1'b0, 3, j));
      check("R12 ch1", tout[1], per_out(1'b1, 4, j));
      check("R12 ch2", tout[2], per_out(1'b1, 5, j));
    end
    v = tout;
    repeat (4) @(negedge clk);
    check("R13 idle tout stable", tout, v);

    setup(0, 3'b011, 6);
    run_per(0, 1'b1, 6, 0, 3, "R2 before reserved");
    bus_wr(2'd3, 8'hF6);
    bus_wr(2'd3, 8'hC4);
    run_per(0, 1'b1, 6, 4, 14, "R2 reserved select ignored");

    bus_wr(2'd3, {2'd1, 2'b01, 3'b010, 1'b0});
    bus_wr(2'd1, 8'h05);
    run_per(1, 1'b0, 5, 0, 9, "R3 low byte only");
    bus_wr(2'd3, {2'd1, 2'b10, 3'b010, 1'b0});
    bus_wr(2'd1, 8'h01);
    pulse(3'b010);
    bus_wr(2'd3, {2'd1, 2'b00, 4'b0000});
    bus_rd(2'd1, d);
    check("R3 high byte only reload 256", d, 1);
    pulse(3'b010);
    bus_wr(2'd3, {2'd1, 2'b00, 4'b0000});
    bus_rd(2'd1, d);
    check("R3 high byte read after one count", d, 0);

    setup(2, 3'b010, 0);
    pulse(3'b100);
    latch_read(2, v);
    check("R7 zero reload loads 65536", v, 0);
    pulse(3'b100);
    latch_read(2, v);
    check("R7 count after one clock", v, 16'hFFFF);
    check("R7 output high", tout[2], 1);

    setup(0, 3'b010, 300);
    repeat (4) pulse(3'b001);
    bus_wr(2'd3, 8'h00);
    repeat (5) pulse(3'b001);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, d);
    check("R9 latched low byte", d, 8'h29);
    pulse(3'b001);
    bus_rd(2'd0, d);
    check("R9 latched high byte", d, 8'h01);
    bus_rd(2'd0, d);
    check("R9 released live low byte", d, 8'h23);
    bus_rd(2'd0, d);
    check("R9 released live high byte", d, 8'h01);
    bus_rd(2'd3, d);
    check("R9 control address reads zero", d, 0);

    setup(1, 3'b011, 8);
    run_per(1, 1'b1, 8, 0, 5, "R8 before gate");
    @(negedge clk); gate[1] = 1'b0;
    @(negedge clk);
    check("R8 gate low forces high", tout[1], 1);
    repeat (3) pulse(3'b010);
    check("R8 gated output still high", tout[1], 1);
    latch_read(1, v);
    check("R8 gated count frozen", v, 3);
    @(negedge clk); gate[1] = 1'b1;
    @(negedge clk);
    run_per(1, 1'b1, 8, 0, 15, "R8 restart after gate rise");

    bus_wr(2'd3, {2'd2, 2'b11, 3'b000, 1'b0});
    check("R10 low after programming", tout[2], 0);
    bus_wr(2'd2, 8'h04);
    bus_wr(2'd2, 8'h00);
    check("R10 low after reload", tout[2], 0);
    for (int j = 0; j <= 7; j++) begin
      if (j == 2) begin
        @(negedge clk); gate[2] = 1'b0;
        repeat (2) pulse(3'b100);
        check("R10 gate low pauses", tout[2], 0);
        @(negedge clk); gate[2] = 1'b1;
      end
      pulse(3'b100);
      check("R10 terminal count output", tout[2], int'(j >= 4));
    end
    latch_read(2, v);
    check("R10 halted at zero", v, 0);
    bus_wr(2'd2, 8'h03);
    bus_wr(2'd2, 8'h00);
    check("R10 rewrite drives low", tout[2], 0);

    setup(0, 3'b010, 4);
    run_per(0, 1'b0, 4, 0, 1, "R11 before new reload");
    bus_wr(2'd0, 8'h06);
    bus_wr(2'd0, 8'h00);
    run_per(0, 1'b0, 4, 2, 3, "R11 old period completes");
    for (int j = 4; j <= 15; j++) begin
      pulse(3'b001);
      check("R11 new period", tout[0], per_out(1'b0, 6, j - 4));
    end

    for (int it = 0; it < 40; it++) begin
      int ch = $urandom_range(0, 2);
      logic [1:0] r = 2'($urandom_range(0, 3));
      logic [2:0] md = {r[1], 1'b1, r[0]};
      int n = $urandom_range(2, 60);
      int k = $urandom_range(n, 3 * n);
      setup(ch, md, n);
      for (int j = 0; j < k; j++) begin
        if ($urandom_range(0, 3) == 0) @(negedge clk);
        pulse(3'($urandom_range(0, 7)) | 3'(1 << ch));
        check(md[0] ? "R6 random square" : "R5 random rate",
              tout[ch], per_out(md[0], n, j));
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule